// File: doc/BRIEF.md
# Priority Pending-Bit Task Dispatcher

This block schedules run-to-completion tasks the way an interrupt controller schedules request sources. Each task owns one source, and each source has a pending bit, an enable and a task priority. A source becomes pending through its timer request input or through a software write. The block offers a dispatch whenever the strongest enabled pending request outranks the level the processor is running at. It then keeps a nesting stack of preempted levels, so work is strictly nested: a preempted level resumes only after every level above it has returned.

There are two request modes. In time-triggered mode every source requests at one shared trigger priority. After dispatch the handler drops to its own execution priority, so any task triggered later preempts the earlier one and the tasks run in stack order. In schedule-table mode a source requests at its own task priority. A low-priority activation then only sets its pending bit and waits, and higher-priority work is not interrupted.

The register write port is a valid/ready stream that is always ready: `wr_ready` is held high, so a write is taken on every cycle in which `wr_valid` is high. The dispatch offer is a valid/ready pair. An offer may stay up for any number of cycles while `disp_ready` is low. It is taken on the clock edge where both signals are high. Drop and return are plain single-cycle pulses.

Top module: `tdisp_top`

## Requirements
- R1: After reset, all per-source priority and enable registers, the trigger priority, the mode, the pending bits, the current level, the nesting depth and the error flag are zero, and `disp_valid` is low.
- R2: A write selects its target with `wr_addr[4:3]`: 0 sets the task priority of source `wr_addr[2:0]`, 1 sets its enable register (bit 0 enables), 2 marks it pending (data ignored), and 3 writes a global register (index 0 is the trigger priority, index 1 bit 0 selects time-triggered mode). `wr_ready` is always high.
- R3: A timer request bit or a pending write sets the pending bit of an enabled source only. For a disabled source the stimulus leaves the pending bits and `disp_valid` unchanged.
- R4: `disp_valid` is high exactly when the best enabled pending request priority is strictly above `cur_prio`, the stack is not full and `ret_req` is low. Otherwise the pending source waits and the current work is not disturbed.
- R5: Among pending sources with equal request priority, the lowest index is offered.
- R6: The request priority is the shared trigger priority in time-triggered mode and the source's own task priority in schedule-table mode. It appears on `disp_prio`.
- R7: When a dispatch is taken, the source's pending bit clears, the previous {source, level} is pushed, and `cur_prio` becomes the request priority. A set of the same source in that same cycle leaves it pending.
- R8: The nesting stack holds 8 entries. When it is full, no dispatch is offered.
- R9: A `lvl_drop` pulse sets `cur_prio` to the running source's task priority. It is ignored when nothing is nested.
- R10: A `ret_req` pulse pops the stack and restores the preempted source and level, so nesting is strict.
- R11: A `ret_req` with an empty stack sets the sticky `err_o` flag and leaves `cur_prio` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write valid |
| wr_ready | output | 1 | Register write ready (always high) |
| wr_addr | input | 5 | Target select [4:3] and source index [2:0] |
| wr_data | input | 8 | Write data |
| tmr_req | input | 8 | Per-source timer activation, one bit per source |
| disp_valid | output | 1 | Dispatch offered |
| disp_ready | input | 1 | Dispatch acknowledge |
| disp_id | output | 3 | Source being offered |
| disp_prio | output | 8 | Request priority of the offered source |
| lvl_drop | input | 1 | Lower the running level to its execution priority |
| ret_req | input | 1 | Running task has finished |
| cur_prio | output | 8 | Current running level |
| nest_depth | output | 4 | Number of stacked preempted levels |
| pend_o | output | 8 | Pending bits |
| err_o | output | 1 | Sticky return-underflow flag |

## Verification
Two functions can act on one pending bit in the same cycle: a dispatch being taken clears the bit, and a timer request for the same source sets it again. The bench provokes this by holding back `disp_ready` while source 0 is pending. It then raises the acknowledge and the timer bit on the same edge. It judges the result by seeing the dispatch go out, by seeing the source still pending at the new level with no second offer, and by seeing the source dispatched again once the return has lowered the level.

// File: rtl/tdisp_pkg.sv
package tdisp_pkg;
  localparam int SRC_N  = 8;
  localparam int PRIO_W = 8;
  localparam int NEST_N = 8;

  typedef enum logic [1:0] {
    SEL_PRIO = 2'd0,
    SEL_EN   = 2'd1,
    SEL_PEND = 2'd2,
    SEL_GLOB = 2'd3
  } sel_e;
endpackage

// File: rtl/tdisp_arb.sv
module tdisp_arb #(
  parameter int NSRC = 8,
  parameter int PW   = 8,
  parameter int IW   = 3
) (
  input  logic [NSRC-1:0] req,
  input  logic [PW-1:0]   prio [NSRC],
  output logic            any,
  output logic [IW-1:0]   win_id,
  output logic [PW-1:0]   win_prio
);
  // strict greater-than keeps the lowest index on a tie
  always_comb begin
    any      = 1'b0;
    win_id   = '0;
    win_prio = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && (!any || prio[i] > win_prio)) begin
        any      = 1'b1;
        win_id   = IW'(i);
        win_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/tdisp_stack.sv
module tdisp_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 11,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [W-1:0] mem [DEPTH];

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign dout  = empty ? '0 : mem[AW'(count - 1'b1)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (push && !full) begin
      mem[AW'(count)] <= din;
      count <= count + 1'b1;
    end else if (pop && !empty) begin
      count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/tdisp_top.sv
module tdisp_top
  import tdisp_pkg::*;
#(
  parameter int NSRC  = SRC_N,
  parameter int PW    = PRIO_W,
  parameter int DEPTH = NEST_N,
  localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int AW   = IW + 2,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic [AW-1:0]   wr_addr,
  input  logic [PW-1:0]   wr_data,
  input  logic [NSRC-1:0] tmr_req,
  output logic            disp_valid,
  input  logic            disp_ready,
  output logic [IW-1:0]   disp_id,
  output logic [PW-1:0]   disp_prio,
  input  logic            lvl_drop,
  input  logic            ret_req,
  output logic [PW-1:0]   cur_prio,
  output logic [DW-1:0]   nest_depth,
  output logic [NSRC-1:0] pend_o,
  output logic            err_o
);
  localparam int FW = IW + PW;

  logic [PW-1:0]   prio_r [NSRC];
  logic [PW-1:0]   en_r   [NSRC];
  logic [PW-1:0]   rq_prio [NSRC];
  logic [NSRC-1:0] en_v, sw_set, pend_q, pend_n;
  logic [PW-1:0]   trig_q, cur_q;
  logic [IW-1:0]   cur_id_q;
  logic            mode_tt, err_q;
  sel_e            sel;
  logic [IW-1:0]   idx;

  logic            any;
  logic [IW-1:0]   win_id;
  logic [PW-1:0]   win_prio;
  logic            fire, st_empty, st_full, st_pop;
  logic [FW-1:0]   st_top;

  assign wr_ready = 1'b1;
  assign sel      = sel_e'(wr_addr[AW-1:IW]);
  assign idx      = wr_addr[IW-1:0];

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      assign en_v[g]    = en_r[g][0];
      assign rq_prio[g] = mode_tt ? trig_q : prio_r[g];
    end
  endgenerate

  always_comb begin
    sw_set = '0;
    if (wr_valid && sel == SEL_PEND) sw_set[idx] = 1'b1;
  end

  tdisp_arb #(.NSRC(NSRC), .PW(PW), .IW(IW)) u_arb (
    .req(pend_q & en_v), .prio(rq_prio),
    .any(any), .win_id(win_id), .win_prio(win_prio)
  );

  assign disp_valid = any && (win_prio > cur_q) && !st_full && !ret_req;
  assign disp_id    = win_id;
  assign disp_prio  = win_prio;
  assign fire       = disp_valid && disp_ready;
  assign st_pop     = ret_req && !st_empty;

  tdisp_stack #(.DEPTH(DEPTH), .W(FW)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(fire), .pop(st_pop),
    .din({cur_id_q, cur_q}), .dout(st_top), .count(nest_depth),
    .empty(st_empty), .full(st_full)
  );

  // set after clear: a same-cycle activation survives the dispatch
  always_comb begin
    pend_n = pend_q;
    if (fire) pend_n[win_id] = 1'b0;
    pend_n = pend_n | ((tmr_req | sw_set) & en_v);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        prio_r[i] <= '0;
        en_r[i]   <= '0;
      end
      trig_q  <= '0;
      mode_tt <= 1'b0;
    end else if (wr_valid) begin
      for (int i = 0; i < NSRC; i++) begin
        if (idx == IW'(i) && sel == SEL_PRIO) prio_r[i] <= wr_data;
        if (idx == IW'(i) && sel == SEL_EN)   en_r[i]   <= wr_data;
      end
      if (sel == SEL_GLOB && idx == IW'(0)) trig_q  <= wr_data;
      if (sel == SEL_GLOB && idx == IW'(1)) mode_tt <= wr_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '0;
      cur_q    <= '0;
      cur_id_q <= '0;
      err_q    <= 1'b0;
    end else begin
      pend_q <= pend_n;
      if (ret_req) begin
        if (st_empty) begin
          err_q    <= 1'b1;
          cur_q    <= '0;
          cur_id_q <= '0;
        end else begin
          cur_id_q <= st_top[FW-1:PW];
          cur_q    <= st_top[PW-1:0];
        end
      end else if (fire) begin
        cur_q    <= win_prio;
        cur_id_q <= win_id;
      end else if (lvl_drop && !st_empty) begin
        cur_q <= prio_r[cur_id_q];
      end
    end
  end

  assign cur_prio = cur_q;
  assign pend_o   = pend_q;
  assign err_o    = err_q;
endmodule

// File: rtl/tdisp_chk.sv
module tdisp_chk #(
  parameter int PW    = 8,
  parameter int DEPTH = 8,
  parameter int DW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          disp_valid,
  input logic          disp_ready,
  input logic [PW-1:0] disp_prio,
  input logic [PW-1:0] cur_prio,
  input logic [DW-1:0] nest_depth,
  input logic          ret_req,
  input logic          err_o
);
  assert_outranks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (disp_prio > cur_prio));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_depth == DW'(DEPTH)) |-> !disp_valid);

  assert_push_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready) |=>
      (cur_prio == $past(disp_prio) && nest_depth == DW'($past(nest_depth) + 1'b1)));

  assert_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && nest_depth != '0) |=> (nest_depth == DW'($past(nest_depth) - 1'b1)));

  assert_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && nest_depth == '0) |=> (err_o && cur_prio == '0));

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
endmodule

bind tdisp_top tdisp_chk #(.PW(PW), .DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .disp_prio(disp_prio), .cur_prio(cur_prio), .nest_depth(nest_depth),
  .ret_req(ret_req), .err_o(err_o)
);

// File: tb/tb_tdisp_top.sv
module tb_tdisp_top;
  logic       clk = 0, rst_n = 0;
  logic       wr_valid = 0, disp_ready = 0, lvl_drop = 0, ret_req = 0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0, tmr_req = '0;
  logic       wr_ready, disp_valid, err_o;
  logic [2:0] disp_id;
  logic [7:0] disp_prio, cur_prio, pend_o;
  logic [3:0] nest_depth;

  int n_chk = 0, n_bad = 0;
  logic [10:0] sb_q [$];

  always #2 clk = ~clk;

  tdisp_top dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .tmr_req(tmr_req),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_id(disp_id),
    .disp_prio(disp_prio), .lvl_drop(lvl_drop), .ret_req(ret_req),
    .cur_prio(cur_prio), .nest_depth(nest_depth), .pend_o(pend_o), .err_o(err_o)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: compares every taken dispatch against the scoreboard
  initial forever begin
    @(negedge clk); #1;
    if (rst_n && disp_valid && disp_ready) begin
      n_chk++;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL R7: actual dispatch %0d/%0d expected none", disp_id, disp_prio);
      end else begin
        logic [10:0] e;
        e = sb_q.pop_front();
        if ({disp_id, disp_prio} != e) begin
          n_bad++;
          $display("FAIL R5/R6: actual %0d/%0d expected %0d/%0d",
                   disp_id, disp_prio, e[10:8], e[7:0]);
        end
      end
    end
  end

  task automatic expect_disp(int id, int prio);
    sb_q.push_back({3'(id), 8'(prio)});
  endtask
  task automatic settle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask
  task automatic wr(int sel, int idx, int d);
    @(negedge clk);
    wr_valid = 1; wr_addr = {2'(sel), 3'(idx)}; wr_data = 8'(d);
    @(negedge clk);
    wr_valid = 0;
  endtask
  task automatic tmr(logic [7:0] m);
    @(negedge clk); tmr_req = m;
    @(negedge clk); tmr_req = '0;
  endtask
  task automatic ret1();
    @(negedge clk); ret_req = 1;
    @(negedge clk); ret_req = 0;
  endtask
  task automatic drop1();
    @(negedge clk); lvl_drop = 1;
    @(negedge clk); lvl_drop = 0;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1;
    settle(1);
    // R1 reset state
    check("R1 cur", cur_prio, 0);
    check("R1 depth", nest_depth, 0);
    check("R1 err", err_o, 0);
    check("R1 valid", disp_valid, 0);
    check("R1 pend", pend_o, 0);
    check("R2 ready", wr_ready, 1);

    // schedule-table mode configuration (R2)
    wr(0, 0, 3); wr(0, 1, 5); wr(0, 2, 5); wr(0, 3, 2);
    for (int i = 0; i < 4; i++) wr(1, i, 1);
    disp_ready = 1;

    // R5 tie, R6 own priority
    expect_disp(1, 5);
    tmr(8'b0000_0110);
    settle(2);
    check("R7 cur", cur_prio, 5);
    check("R7 depth", nest_depth, 1);
    check("R4 wait equal", disp_valid, 0);
    check("R5 loser pending", pend_o, 8'b0000_0100);
    // R4 low activation only pends
    tmr(8'b0000_1000);
    settle(1);
    check("R4 low pends", pend_o, 8'b0000_1100);
    check("R4 no interrupt", cur_prio, 5);

    expect_disp(2, 5);
    ret1(); settle(2);
    check("R10 redispatch", cur_prio, 5);
    expect_disp(3, 2);
    ret1(); settle(2);
    check("R4 low runs", cur_prio, 2);
    ret1(); settle(1);
    check("R10 idle", cur_prio, 0);
    check("R10 depth", nest_depth, 0);
    check("R11 no err yet", err_o, 0);
    ret1(); settle(1);
    check("R11 err", err_o, 1);
    check("R11 cur", cur_prio, 0);

    // nesting by software writes
    expect_disp(0, 3);
    wr(2, 0, 0); settle(2);
    check("R2 sw pend", cur_prio, 3);
    expect_disp(1, 5);
    wr(2, 1, 0); settle(2);
    check("R10 preempt", cur_prio, 5);
    check("R10 depth2", nest_depth, 2);
    ret1(); settle(1);
    check("R10 resume", cur_prio, 3);
    ret1(); settle(1);
    check("R10 back idle", cur_prio, 0);

    // time-triggered mode (R6, R9)
    wr(3, 0, 200); wr(3, 1, 1);
    expect_disp(3, 200);
    tmr(8'b0000_1000); settle(2);
    check("R6 trigger level", cur_prio, 200);
    drop1(); settle(1);
    check("R9 drop", cur_prio, 2);
    expect_disp(0, 200);
    tmr(8'b0000_0001); settle(2);
    check("R6 later preempts", cur_prio, 200);
    check("R6 depth", nest_depth, 2);
    drop1(); settle(1);
    check("R9 drop2", cur_prio, 3);
    ret1(); settle(1);
    check("R10 dropped level back", cur_prio, 2);
    ret1(); settle(1);
    drop1(); settle(1);
    check("R9 idle ignored", cur_prio, 0);

    // R3 disabled source
    tmr(8'b0001_0000); settle(1);
    check("R3 tmr disabled", pend_o, 0);
    wr(2, 4, 0); settle(1);
    check("R3 sw disabled", pend_o, 0);
    check("R3 no offer", disp_valid, 0);
    wr(3, 1, 0);

    // R7 same-cycle clear and set
    disp_ready = 0;
    wr(2, 0, 0); settle(1);
    check("R4 offer held", disp_valid, 1);
    expect_disp(0, 3);
    @(negedge clk); disp_ready = 1; tmr_req = 8'b0000_0001;
    @(negedge clk); tmr_req = '0;
    #1;
    check("R7 cur", cur_prio, 3);
    check("R7 still pending", pend_o[0], 1);
    check("R7 no second offer", disp_valid, 0);
    expect_disp(0, 3);
    ret1(); settle(2);
    check("R7 redispatched", cur_prio, 3);
    check("R7 pend cleared", pend_o, 0);
    ret1(); settle(1);

    // R8 full stack
    for (int i = 0; i < 8; i++) wr(0, i, 10 + i);
    for (int i = 4; i < 8; i++) wr(1, i, 1);
    for (int i = 0; i < 8; i++) begin
      expect_disp(i, 10 + i);
      wr(2, i, 0);
      settle(2);
    end
    check("R8 depth full", nest_depth, 8);
    check("R8 cur", cur_prio, 17);
    wr(0, 0, 30); wr(2, 0, 0); settle(1);
    check("R8 blocked", disp_valid, 0);
    expect_disp(0, 30);
    ret1(); settle(2);
    check("R8 after pop", cur_prio, 30);
    check("R8 refilled", nest_depth, 8);

    settle(2);
    check("R7 scoreboard drained", sb_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule